// File: doc/BRIEF.md
# Chaotic Keystream XOR Cipher

This block turns a stream of 16-bit data words into ciphertext. Each word is XORed with a keystream word taken from a three-variable chaotic iterator. The iterator is a forward-Euler discretisation of a Lorenz-type flow, held in signed Q16.16 fixed point. A 16-bit key seeds the three state variables, so two copies of the block loaded with the same key produce the same keystream. Because XOR is its own inverse, one copy encrypts and a second copy decrypts.

The data word comes either from an external port with a valid/ready handshake or from an internal 16-bit counter that acts as a test plaintext source. Every accepted word produces a registered ciphertext one clock later. Alongside it come two monitor copies: the raw word that was used and the keystream word that was applied to it. The iterator advances `ITERS` Euler steps per keystream word. With the default of two steps, a fully fed stream yields eight words, or 128 bits, in every 16 cycles.

Top module: `chaos_xor_cipher`

## Requirements
- R1: Every result satisfies `ct_data == mon_raw ^ mon_ks`. `mon_raw` equals the data word accepted in the previous cycle.
- R2: A word is accepted on a rising edge when `in_ready` is high, `key_load` is low and either `src_sel` is 1 or `in_valid` is 1. `ct_valid` is high in exactly the cycle after each acceptance and low otherwise.
- R3: `in_ready` is high exactly when a keystream word is waiting. A waiting word stays waiting, with `in_ready` high and no output, until it is consumed or a key load occurs. While `in_ready` is low, `in_valid` has no effect.
- R4: With `src_sel` = 1 the data word is the internal counter and `in_valid` is ignored. The counter is 0 for the first word after a key load and rises by 1 per accepted word.
- R5: A `key_load` edge reseeds the iterator from `key` and clears the counter. In the next cycle `ct_valid` and `in_ready` are both low. `key_load` takes priority over an acceptance in the same cycle. Reloading the same key reproduces the same keystream sequence.
- R6: A second instance loaded with the same key recovers the plaintext bit for bit when fed the ciphertext. Its keystream matches the first instance's word for word.
- R7: A different key produces a keystream that does not reproduce the plaintext from the same ciphertext.
- R8: With data always offered and the default `ITERS` = 2, `ct_valid` is never high in two consecutive cycles, and exactly 8 results appear in every 16-cycle window.
- R9: While `rst` is high, `ct_valid` and `in_ready` are low. After reset the iterator runs from the seed given by `RESET_KEY`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_load | input | 1 | Reseed iterator from `key` and clear counter |
| key | input | DW | Seed value |
| src_sel | input | 1 | 0: external data, 1: internal counter |
| in_valid | input | 1 | External word offered |
| in_data | input | DW | External data word |
| in_ready | output | 1 | Keystream word available |
| ct_valid | output | 1 | Result valid |
| ct_data | output | DW | Ciphertext (or recovered plaintext) |
| mon_raw | output | DW | Raw data word used for the result |
| mon_ks | output | DW | Keystream word used for the result |

## Verification
A key load can arrive in the same cycle as an acceptance: a keystream word is waiting and data is offered. To provoke this, the bench runs the counter source continuously and raises `key_load` in a cycle where `in_ready` is high. The reload must win. No result may appear in the next cycle. The first result after the reload must carry counter value 0 and the first keystream word that was recorded earlier for that key.

// File: rtl/chaos_xor_cipher.sv
module chaos_xor_cipher #(
  parameter int DW = 16,
  parameter int SW = 32,
  parameter int FRAC = 16,
  parameter int DT_SHIFT = 7,
  parameter int ITERS = 2,
  parameter logic [DW-1:0] RESET_KEY = 16'h1D2B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_load,
  input  logic [DW-1:0] key,
  input  logic          src_sel,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          ct_valid,
  output logic [DW-1:0] ct_data,
  output logic [DW-1:0] mon_raw,
  output logic [DW-1:0] mon_ks
);
  localparam int PW  = 2 * SW;
  localparam int PHW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [PHW-1:0] PH_LAST = PHW'(ITERS - 1);
  localparam logic signed [SW-1:0] K_SIG  = SW'(10);
  localparam logic signed [SW-1:0] K_RHO  = SW'(28) <<< FRAC;
  localparam logic signed [SW-1:0] K_BETA = SW'((8 << FRAC) / 3);
  localparam logic signed [SW-1:0] K_ONE  = SW'(1) <<< FRAC;

  logic signed [SW-1:0] x_q, y_q, z_q, x_n, y_n, z_n;
  logic signed [SW-1:0] dx, dy, dz, t_xz, t_xy, t_bz;
  logic signed [PW-1:0] p_xz, p_xy, p_bz;
  logic [PHW-1:0] phase;
  logic           ks_vld;
  logic [DW-1:0]  ks_word, ks_n, cnt, raw, seed;
  logic           take, run, last;

  function automatic logic signed [SW-1:0] seed_var(input logic [DW-1:0] k);
    seed_var = K_ONE + SW'(k);
  endfunction

  always_comb begin
    p_xz = PW'(x_q) * PW'(K_RHO - z_q);
    p_xy = PW'(x_q) * PW'(y_q);
    p_bz = PW'(z_q) * PW'(K_BETA);
    t_xz = SW'(p_xz >>> FRAC);
    t_xy = SW'(p_xy >>> FRAC);
    t_bz = SW'(p_bz >>> FRAC);
    dx = (K_SIG * (y_q - x_q)) >>> DT_SHIFT;
    dy = (t_xz - y_q) >>> DT_SHIFT;
    dz = (t_xy - t_bz) >>> DT_SHIFT;
    x_n = x_q + dx;
    y_n = y_q + dy;
    z_n = z_q + dz;
  end

  assign ks_n = x_n[FRAC+DW/2-1 -: DW] ^ y_n[DW-1:0] ^ {z_n[DW/2-1:0], z_n[DW-1:DW/2]};
  assign raw  = src_sel ? cnt : in_data;
  assign take = ks_vld & (src_sel | in_valid) & ~key_load;
  assign run  = ~ks_vld | take;
  assign last = (phase == PH_LAST);
  assign seed = rst ? RESET_KEY : key;
  assign in_ready = ks_vld;

  always_ff @(posedge clk) begin
    if (rst || key_load) begin
      x_q      <= seed_var(seed);
      y_q      <= seed_var(~seed);
      z_q      <= seed_var(seed ^ 16'hA5C3);
      phase    <= '0;
      ks_vld   <= 1'b0;
      ks_word  <= '0;
      cnt      <= '0;
      ct_valid <= 1'b0;
      ct_data  <= '0;
      mon_raw  <= '0;
      mon_ks   <= '0;
    end else begin
      ct_valid <= take;
      if (take) begin
        ct_data <= raw ^ ks_word;
        mon_raw <= raw;
        mon_ks  <= ks_word;
        if (src_sel) cnt <= cnt + 1'b1;
      end
      if (run) begin
        x_q <= x_n;
        y_q <= y_n;
        z_q <= z_n;
        phase <= last ? '0 : phase + 1'b1;
      end
      if (run && last) begin
        ks_word <= ks_n;
        ks_vld  <= 1'b1;
      end else if (take) begin
        ks_vld <= 1'b0;
      end
    end
  end
endmodule

module chaos_xor_cipher_chk (
  input logic clk,
  input logic rst,
  input logic key_load,
  input logic src_sel,
  input logic in_valid,
  input logic in_ready,
  input logic ct_valid
);
  // R2
  accept_gives_result_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !key_load && (src_sel || in_valid)) |=> ct_valid);
  // R3
  no_ready_no_result_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !key_load) |=> !ct_valid);
  // R3
  ready_held_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !key_load && !src_sel && !in_valid) |=> (in_ready && !ct_valid));
  // R5
  reload_clears_chk: assert property (@(posedge clk) disable iff (rst)
    key_load |=> (!ct_valid && !in_ready));
  // R8
  result_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    ct_valid |=> !ct_valid);
endmodule

bind chaos_xor_cipher chaos_xor_cipher_chk u_chk (
  .clk(clk), .rst(rst), .key_load(key_load), .src_sel(src_sel),
  .in_valid(in_valid), .in_ready(in_ready), .ct_valid(ct_valid)
);

// File: tb/test_chaos_xor_cipher.sv
module test_chaos_xor_cipher;
  localparam int CLK_NS = 10;
  localparam int N = 24;

  logic clk = 0, rst = 1;
  logic e_kl = 0, e_src = 0, e_iv = 0, e_rdy, e_cv;
  logic [15:0] e_key = 0, e_in = 0, e_ct, e_raw, e_ks;
  logic d_kl = 0, d_iv = 0, d_rdy, d_cv;
  logic [15:0] d_key = 0, d_in = 0, d_ct, d_raw, d_ks;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] pt [N];
  logic [15:0] ctv [N];
  logic [15:0] ksv [N];
  logic [15:0] first_ks;

  always #(CLK_NS/2) clk = ~clk;

  chaos_xor_cipher i_chaos_xor_cipher (
    .clk(clk), .rst(rst), .key_load(e_kl), .key(e_key), .src_sel(e_src),
    .in_valid(e_iv), .in_data(e_in), .in_ready(e_rdy), .ct_valid(e_cv),
    .ct_data(e_ct), .mon_raw(e_raw), .mon_ks(e_ks));

  chaos_xor_cipher i_dec (
    .clk(clk), .rst(rst), .key_load(d_kl), .key(d_key), .src_sel(1'b0),
    .in_valid(d_iv), .in_data(d_in), .in_ready(d_rdy), .ct_valid(d_cv),
    .ct_data(d_ct), .mon_raw(d_raw), .mon_ks(d_ks));

  function automatic logic [15:0] exp_xor(input logic [15:0] a, input logic [15:0] b);
    return a ^ b;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic load_enc(input logic [15:0] k);
    e_key = k; e_kl = 1;
    @(negedge clk); e_kl = 0;
    chk(!e_cv && !e_rdy, "R5 reload clears", {e_cv, e_rdy}, 0);
  endtask

  task automatic load_dec(input logic [15:0] k);
    d_key = k; d_kl = 1;
    @(negedge clk); d_kl = 0;
    chk(!d_cv && !d_rdy, "R5 reload clears dec", {d_cv, d_rdy}, 0);
  endtask

  task automatic enc_word(input logic [15:0] d, output logic [15:0] c, output logic [15:0] k);
    e_in = d; e_iv = 1;
    while (!e_rdy) begin
      @(negedge clk);
      if (!e_rdy) chk(!e_cv, "R3 stall no output", e_cv, 0);
    end
    @(negedge clk);
    e_iv = 0;
    chk(e_cv, "R2 result one cycle later", e_cv, 1);
    chk(e_raw == d, "R1 raw monitor", e_raw, d);
    chk(e_ct == exp_xor(d, e_ks), "R1 ct xor", e_ct, exp_xor(d, e_ks));
    c = e_ct; k = e_ks;
  endtask

  task automatic dec_word(input logic [15:0] c, output logic [15:0] p, output logic [15:0] k);
    d_in = c; d_iv = 1;
    while (!d_rdy) @(negedge clk);
    @(negedge clk);
    d_iv = 0;
    p = d_ct; k = d_ks;
  endtask

  initial begin
    for (int i = 0; i < 50000; i++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] c, k, p;
    int mism, nv, seen;
    bit prev;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(!e_cv && !e_rdy, "R9 reset state", {e_cv, e_rdy}, 0);
    rst = 0;
    @(negedge clk);
    chk(!e_rdy, "R9 ready after one step", e_rdy, 0);
    @(negedge clk);
    chk(e_rdy, "R9 ready after reset seed", e_rdy, 1);
    repeat (3) @(negedge clk);
    chk(e_rdy && !e_cv, "R3 word held while idle", {e_rdy, e_cv}, 2);

    load_enc(16'hBEEF);
    for (int i = 0; i < N; i++) begin
      pt[i] = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'($urandom);
      enc_word(pt[i], c, k);
      ctv[i] = c; ksv[i] = k;
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    load_dec(16'hBEEF);
    for (int i = 0; i < N; i++) begin
      dec_word(ctv[i], p, k);
      chk(p == pt[i], "R6 plaintext recovered", p, pt[i]);
      chk(k == ksv[i], "R6 keystream matches", k, ksv[i]);
    end

    load_dec(16'h4C1A);
    mism = 0;
    for (int i = 0; i < N; i++) begin
      dec_word(ctv[i], p, k);
      if (p != pt[i]) mism++;
    end
    chk(mism > 0, "R7 wrong key fails", mism, 1);

    load_enc(16'hBEEF);
    for (int i = 0; i < 4; i++) begin
      enc_word(pt[i], c, k);
      chk(c == ctv[i], "R5 same key same ciphertext", c, ctv[i]);
    end

    e_src = 1; e_iv = 0;
    load_enc(16'h7A31);
    seen = 0; nv = 0; prev = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      if (e_cv) begin
        chk(e_raw == 16'(seen), "R4 counter value", e_raw, seen);
        chk(e_ct == exp_xor(e_raw, e_ks), "R1 counter ct", e_ct, exp_xor(e_raw, e_ks));
        if (seen == 0) first_ks = e_ks;
        seen++;
        if (cyc >= 8 && cyc < 24) nv++;
      end
      if (prev && e_cv) chk(0, "R8 back to back results", 1, 0);
      prev = e_cv;
    end
    chk(nv == 8, "R8 eight per sixteen", nv, 8);

    while (!e_rdy) @(negedge clk);
    e_key = 16'h7A31; e_kl = 1;
    @(negedge clk); e_kl = 0;
    chk(!e_cv && !e_rdy, "R5 reload beats accept", {e_cv, e_rdy}, 0);
    while (!e_cv) @(negedge clk);
    chk(e_raw == 16'h0000, "R5 counter restarted", e_raw, 0);
    chk(e_ks == first_ks, "R5 keystream restarted", e_ks, first_ks);

    e_src = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule